// File: doc/BRIEF.md
# Multiplexed Peripheral Bus Cycle Sequencer with Windowed Selects

This block runs read and write cycles on an 8-bit multiplexed address/data bus for a simple core. A one-clock request carrying an 11-bit I/O address, a direction and write data starts a cycle. The cycle then steps through the phases T1, T2, T3, optional wait clocks and T4. During these phases the block drives the address latch strobe, the active-low read and write strobes, and the shared bus lines with their output enable.

The upper address bits pick one of eight 256-byte windows. Six of the windows own an active-low peripheral select. Window 4 and window 7 have no select. The selects on the first four windows are slow devices and stretch every cycle by a long wait period. The two upper selects stretch it by a short one. Wait periods are given in nanoseconds and converted to clocks from the clock period parameter.

A hold input forces every select high. It does not stop the cycle itself. One clock after T4 the block returns an acknowledge pulse, together with the byte it read.

Top module: `pbus_cs_ctrl`

## Requirements
- R1: After reset, all six selects are high, the address strobe is low, both read and write strobes are high, the bus output enable is low and the acknowledge is low.
- R2: The select that goes low is chosen by address bits [10:8]. Values 0, 1, 2 and 3 drive `sel_n[0]`..`sel_n[3]` low. Value 5 drives `sel_n[4]` low and value 6 drives `sel_n[5]` low. At most one select is low at a time, and it stays low from T1 through T4.
- R3: An address whose bits [10:8] are 4 or 7 asserts no select and completes in exactly 4 cycle clocks (T1..T4), with no waits.
- R4: In T1, and only in T1, the address strobe is high. In that clock the bus is driven with address bits [7:0] and the decoded select is already low. Neither the read nor the write strobe is low while the address strobe is high.
- R5: In a read, the bus output enable is low from T2 onward. The read strobe is low from T3 through T4 and is never low while the bus is driven.
- R6: In a write, the write strobe is low from T2 through T4. The bus carries the write data with the output enable high until the end of T4.
- R7: Waits are inserted between T3 and T4. Selects 0..3 add ceil(800 ns / CLK_NS) clocks and selects 4..5 add ceil(150 ns / CLK_NS) clocks. With CLK_NS = 50, the cycle lasts 20 and 7 clocks respectively.
- R8: `ack` is high for exactly one clock, the clock after T4. In a read, `rdata` then holds the value present on `ad_in` during T4.
- R9: While `hold` is high, every select is high. The cycle still runs with its decoded length.
- R10: A request raised while a cycle is in progress is ignored. It neither changes the running cycle nor starts a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a cycle (taken only when idle) |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 11 | I/O address |
| wdata | input | 8 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte sampled in T4 of a read |
| hold | input | 1 | Forces all selects high |
| ale | output | 1 | Address latch strobe, high in T1 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ad_out | output | 8 | Bus value (address in T1, write data later) |
| ad_oe | output | 1 | Bus output enable |
| ad_in | input | 8 | Bus value driven by the peripheral |
| sel_n | output | 6 | Active-low peripheral selects |

## Verification
The bench uses the default parameters: CLK_NS = 50, an 800 ns long wait and a 150 ns short wait. These give 16 and 3 wait clocks, so the long window's 20-clock cycle, the short window's 7-clock cycle and the 4-clock no-select cycle can all be told apart by counting clocks. The 11-bit address reaches every window, including the two unselected ones at 4 and 7, so the gap in the map is exercised at both ends. Each scenario walks one whole cycle and records, clock by clock, when each strobe and select is low.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  // number of select outputs and how many belong to the slow group
  localparam int NSEL       = 6;
  localparam int SLOW_COUNT = 4;

  // window number owned by a select slot: slots past the slow group skip window 4
  function automatic int slot_window(input int slot);
    return (slot < SLOW_COUNT) ? slot : slot + 1;
  endfunction

  // round a duration up to whole clocks
  function automatic int ns_to_clocks(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/pbus_sel_decode.sv
module pbus_sel_decode
  import pbus_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int WAIT_W      = 5,
  parameter int LONG_WAITS  = 16,
  parameter int SHORT_WAITS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NSEL-1:0]   hit,
  output logic [WAIT_W-1:0] waits
);
  localparam int WIN_W = ADDR_W - 8;

  for (genvar i = 0; i < NSEL; i++) begin : g_slot
    assign hit[i] = (addr[ADDR_W-1:8] == WIN_W'(slot_window(i)));
  end

  always_comb begin
    waits = '0;
    for (int i = 0; i < NSEL; i++) begin
      if (hit[i]) begin
        waits = (i < SLOW_COUNT) ? WAIT_W'(LONG_WAITS) : WAIT_W'(SHORT_WAITS);
      end
    end
  end

endmodule

// File: rtl/pbus_wait_timer.sv
module pbus_wait_timer #(
  parameter int WAIT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] count_in,
  input  logic              tick,
  output logic              last
);
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= count_in;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - WAIT_W'(1);
    end
  end

  assign last = (cnt == WAIT_W'(1));

  // R7: a wait clock is only spent while the counter still holds waits
  assert_wait_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> cnt != '0);

endmodule

// File: rtl/pbus_phase_seq.sv
module pbus_phase_seq
  import pbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   has_waits,
  input  logic   wait_last,
  output phase_e phase,
  output logic   load_wait,
  output logic   in_wait
);
  phase_e nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: if (start) nxt = PH_T1;
      PH_T1:   nxt = PH_T2;
      PH_T2:   nxt = PH_T3;
      PH_T3:   nxt = has_waits ? PH_TW : PH_T4;
      PH_TW:   if (wait_last) nxt = PH_T4;
      PH_T4:   nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  assign load_wait = (phase == PH_T3) && has_waits;
  assign in_wait   = (phase == PH_TW);

  // R7: waits are entered only from T3
  assert_wait_after_t3_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == PH_TW) |-> $past(phase) == PH_T3);

endmodule

// File: rtl/pbus_cs_ctrl.sv
module pbus_cs_ctrl
  import pbus_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int CLK_NS        = 50,
  parameter int LONG_WAIT_NS  = 800,
  parameter int SHORT_WAIT_NS = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              ack,
  output logic [7:0]        rdata,
  input  logic              hold,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [7:0]        ad_out,
  output logic              ad_oe,
  input  logic [7:0]        ad_in,
  output logic [NSEL-1:0]   sel_n
);
  localparam int LONG_WAITS  = ns_to_clocks(LONG_WAIT_NS, CLK_NS);
  localparam int SHORT_WAITS = ns_to_clocks(SHORT_WAIT_NS, CLK_NS);
  localparam int MAX_WAITS   = (LONG_WAITS > SHORT_WAITS) ? LONG_WAITS : SHORT_WAITS;
  localparam int WAIT_W      = $clog2(MAX_WAITS + 1) + 1;

  phase_e            phase;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [7:0]        wdata_q;
  logic [NSEL-1:0]   hit;
  logic [WAIT_W-1:0] waits;
  logic              load_wait, in_wait, wait_last;

  // named events
  logic cyc_start, cyc_end, data_phase, strobe_phase;
  assign cyc_start    = (phase == PH_IDLE) && req;
  assign cyc_end      = (phase == PH_T4);
  assign data_phase   = (phase == PH_T2) || strobe_phase;
  assign strobe_phase = (phase == PH_T3) || (phase == PH_TW) || (phase == PH_T4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (cyc_start) begin
      addr_q  <= addr;
      we_q    <= we;
      wdata_q <= wdata;
    end
  end

  pbus_sel_decode #(
    .ADDR_W(ADDR_W), .WAIT_W(WAIT_W),
    .LONG_WAITS(LONG_WAITS), .SHORT_WAITS(SHORT_WAITS)
  ) u_dec (
    .addr(addr_q), .hit(hit), .waits(waits)
  );

  pbus_phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(cyc_start),
    .has_waits(waits != '0), .wait_last(wait_last),
    .phase(phase), .load_wait(load_wait), .in_wait(in_wait)
  );

  pbus_wait_timer #(.WAIT_W(WAIT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(load_wait), .count_in(waits),
    .tick(in_wait), .last(wait_last)
  );

  assign sel_n  = (hold || phase == PH_IDLE) ? '1 : ~hit;
  assign ale    = (phase == PH_T1);
  assign ad_oe  = (phase == PH_T1) || (we_q && data_phase);
  assign ad_out = (phase == PH_T1) ? addr_q[7:0] : wdata_q;
  assign rd_n   = !(!we_q && strobe_phase);
  assign wr_n   = !(we_q && data_phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= cyc_end;
      if (cyc_end && !we_q) rdata <= ad_in;
    end
  end

  // R2: never two selects at once
  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sel_n));
  // R9: hold wins over decode
  assert_hold_sel_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> sel_n == '1);
  // R5: the read strobe never overlaps a driven bus
  assert_rd_bus_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  // R4: no strobe during the address strobe
  assert_ale_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));
  // R8: acknowledge is a single pulse
  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R10: the latched address is frozen while a cycle runs
  assert_addr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && phase != PH_T1) |-> $stable(addr_q));

endmodule

// File: tb/sim_pbus_cs_ctrl.sv
`timescale 1ns/1ps
module sim_pbus_cs_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, hold = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0] wdata = '0, ad_in = '0;
  logic ack, ale, rd_n, wr_n, ad_oe;
  logic [7:0] rdata, ad_out;
  logic [5:0] sel_n;

  always #2.5 clk = ~clk;

  pbus_cs_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata), .hold(hold), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .sel_n(sel_n)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // per-cycle observations
  int m_len, m_ale, m_ale_k, m_sel_cnt, m_sel_first, m_rd_cnt, m_rd_first;
  int m_wr_cnt, m_wr_first, m_clash, m_bad_wdata, m_oe_read, m_addr_bus;
  logic [5:0] m_sel_mask;
  logic [7:0] m_rdata;

  task automatic run_cycle(input logic w, input logic [10:0] a, input logic [7:0] wd,
                           input logic [7:0] bus_in, input bit poke);
    int k;
    m_len = 0; m_ale = 0; m_ale_k = -1; m_sel_cnt = 0; m_sel_first = -1;
    m_rd_cnt = 0; m_rd_first = -1; m_wr_cnt = 0; m_wr_first = -1;
    m_clash = 0; m_bad_wdata = 0; m_oe_read = 0; m_addr_bus = -1; m_sel_mask = '0;
    ad_in = bus_in;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = wd;
    @(negedge clk);
    req = 1'b0;
    k = 0;
    while (!ack) begin
      if (ale) begin m_ale++; m_ale_k = k; m_addr_bus = ad_oe ? int'(ad_out) : -1; end
      if (sel_n != 6'h3F) begin
        m_sel_cnt++; m_sel_mask |= ~sel_n;
        if (m_sel_first < 0) m_sel_first = k;
      end
      if (!rd_n) begin m_rd_cnt++; if (m_rd_first < 0) m_rd_first = k; if (ad_oe) m_clash++; end
      if (!wr_n) begin
        m_wr_cnt++; if (m_wr_first < 0) m_wr_first = k;
        if (!ad_oe || ad_out != wd) m_bad_wdata++;
      end
      if (!w && k > 0 && ad_oe) m_oe_read++;
      if (poke && k == 1) begin req = 1'b1; we = 1'b1; addr = 11'h000; wdata = 8'hEE; end
      k++;
      if (k > 100) begin check("watchdog cycle", k, 0); break; end
      @(negedge clk);
    end
    m_len = k;
    m_rdata = rdata;
    req = 1'b0;
    @(negedge clk);
    check("R8 ack single clock", int'(ack), 0);
  endtask

  task automatic t_reset;
    check("R1 sel_n", int'(sel_n), 6'h3F);
    check("R1 ale", int'(ale), 0);
    check("R1 rd_n", int'(rd_n), 1);
    check("R1 wr_n", int'(wr_n), 1);
    check("R1 ad_oe", int'(ad_oe), 0);
    check("R1 ack", int'(ack), 0);
  endtask

  task automatic t_read_windows;
    int wins[6] = '{0, 1, 2, 3, 5, 6};
    for (int s = 0; s < 6; s++) begin
      int exp_len = (s < 4) ? 4 + 16 : 4 + 3;
      logic [7:0] lo = 8'hA5 ^ 8'(s);
      run_cycle(1'b0, {3'(wins[s]), lo}, 8'h00, 8'h30 + 8'(s), 1'b0);
      check("R2 select chosen", int'(m_sel_mask), 1 << s);
      check("R2 select held T1..T4", m_sel_cnt, exp_len);
      check("R4 select low in T1", m_sel_first, 0);
      check("R4 one ale clock in T1", m_ale * 10 + m_ale_k, 10);
      check("R4 address on bus", m_addr_bus, int'(lo));
      check("R5 read strobe from T3", m_rd_first, 2);
      check("R5 read strobe length", m_rd_cnt, exp_len - 2);
      check("R5 bus released", m_oe_read + m_clash, 0);
      check("R7 cycle length", m_len, exp_len);
      check("R8 read data", int'(m_rdata), int'(8'h30 + 8'(s)));
    end
  endtask

  task automatic t_writes;
    run_cycle(1'b1, 11'h1C4, 8'h5A, 8'h00, 1'b0);
    check("R6 write strobe from T2", m_wr_first, 1);
    check("R6 write strobe length", m_wr_cnt, 19);
    check("R6 write data driven", m_bad_wdata, 0);
    check("R6 no read strobe", m_rd_cnt, 0);
    check("R2 write select", int'(m_sel_mask), 6'h02);
    run_cycle(1'b1, 11'h63F, 8'hC3, 8'h00, 1'b0);
    check("R6 short write strobe", m_wr_cnt, 6);
    check("R6 short write data", m_bad_wdata, 0);
    check("R7 short write length", m_len, 7);
  endtask

  task automatic t_holes;
    run_cycle(1'b0, 11'h4C3, 8'h00, 8'h11, 1'b0);
    check("R3 window 4 no select", int'(m_sel_mask), 0);
    check("R3 window 4 length", m_len, 4);
    check("R3 window 4 read data", int'(m_rdata), 8'h11);
    run_cycle(1'b0, 11'h7FF, 8'h00, 8'h22, 1'b0);
    check("R3 window 7 no select", int'(m_sel_mask), 0);
    check("R3 window 7 length", m_len, 4);
    run_cycle(1'b1, 11'h400, 8'h99, 8'h00, 1'b0);
    check("R3 window 4 write length", m_len, 4);
    check("R3 window 4 write strobe", m_wr_cnt, 3);
  endtask

  task automatic t_hold;
    hold = 1'b1;
    run_cycle(1'b0, 11'h2AA, 8'h00, 8'h77, 1'b0);
    hold = 1'b0;
    check("R9 selects high in hold", m_sel_cnt, 0);
    check("R9 cycle length kept", m_len, 20);
    check("R9 read completes", int'(m_rdata), 8'h77);
  endtask

  task automatic t_busy;
    int stray = 0;
    run_cycle(1'b0, 11'h512, 8'h00, 8'h4D, 1'b1);
    check("R10 running select unchanged", int'(m_sel_mask), 6'h10);
    check("R10 running length unchanged", m_len, 7);
    check("R10 no write strobe", m_wr_cnt, 0);
    for (int i = 0; i < 6; i++) begin
      if (ale || sel_n != 6'h3F || !wr_n) stray++;
      @(negedge clk);
    end
    check("R10 no later cycle", stray, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_read_windows();
    t_writes();
    t_holes();
    t_hold();
    t_busy();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule